// File: doc/BRIEF.md
# ALU Status Word with Register-Bank Addressing

This block keeps the processor status byte and the small add/subtract path that sets its arithmetic flags. An accumulator value and an operand are added or subtracted, optionally folding in the stored carry as carry-in or borrow-in. The carry, the half carry out of the low nibble and the signed overflow are captured in the status byte. A parity bit always follows the accumulator input. The byte also holds two software flags and a two-bit bank selector.

The carry bit doubles as a one-bit accumulator for Boolean work. It can be ANDed or ORed with a bit operand, complemented, set or cleared. The bank selector steers the working-register addresses: register n of the current bank sits at internal RAM address bank*8+n. For 8-bit indirect access, the block gives the address of pointer register 0 or 1 in that bank. It then forwards the byte read from that location as the operand address.

A whole-byte write port loads every stored bit in one cycle and wins over an ALU update in the same cycle.

Top module: `psw_unit`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears all stored bits 7..1 to 0, selecting bank 0; bit 0 keeps following the accumulator.
- R2: The status byte layout is bit 7 carry, bit 6 half carry, bit 5 software flag A, bit 4 bank high, bit 3 bank low, bit 2 overflow, bit 1 software flag B, bit 0 parity.
- R3: Op code 1 adds acc_i and opnd_i, and op code 2 also adds the stored carry. sum_o gives the 8-bit result combinationally. At the next edge the carry takes the carry out of bit 7 and the half carry takes the carry out of bit 3.
- R4: Op code 3 computes acc_i minus opnd_i, and op code 4 also subtracts the stored carry as a borrow. The carry is set on a borrow out of bit 7 and the half carry on a borrow out of bit 3.
- R5: For op codes 1 to 4, overflow is set when the signed result lies outside -128..127, which equals the carry into bit 7 XOR the carry out of bit 7.
- R6: Bit 0 equals the XOR of all accumulator bits at all times, with no clock edge needed. It cannot be written.
- R7: When sw_wr_i is high at an edge, stored bits 7..1 take sw_wdata_i[7:1]. This takes priority over any ALU op given in the same cycle.
- R8: Op codes 5 (AND with bit_i), 6 (OR with bit_i), 7 (complement), 8 (set) and 9 (clear) change only the carry. Bits 6..1 stay unchanged.
- R9: Op code 0 and codes 10 to 15 leave the stored bits unchanged.
- R10: reg_addr_o equals the bank selector times 8 plus reg_sel_i, zero-extended, using the bank value held now.
- R11: ptr_addr_o equals the bank selector times 8 plus ptr_sel_i. ind_addr_o forwards ptr_rdata_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Second ALU operand |
| alu_op_i | input | 4 | Operation code |
| bit_i | input | 1 | Bit operand for carry AND/OR |
| sw_wr_i | input | 1 | Whole-byte status write strobe |
| sw_wdata_i | input | 8 | Status write data (bit 0 ignored) |
| reg_sel_i | input | 3 | Working register number |
| ptr_sel_i | input | 1 | Pointer register choice, 0 or 1 |
| ptr_rdata_i | input | 8 | Byte read from the pointer register |
| psw_o | output | 8 | Status byte |
| sum_o | output | 8 | Add/subtract result |
| reg_addr_o | output | 8 | RAM address of the working register |
| ptr_addr_o | output | 8 | RAM address of the pointer register |
| ind_addr_o | output | 8 | Indirect operand address |

## Verification
Two situations are hard to reach from the ports. One is a write and an arithmetic op that land in the same cycle. The other is a carry-dependent op that runs while the stored carry is already 1. The stimulus first preloads the carry through the write port, then runs add-with-carry and subtract-with-borrow on operands that also cross the nibble boundary. A later cycle drives the write strobe together with an add whose flags would differ from the written byte. The overflow cases use both sign directions and the 0x80 boundary.

// File: rtl/psw_pkg.sv
package psw_pkg;
   typedef enum logic [3:0] {
      OP_NOP  = 4'd0,
      OP_ADD  = 4'd1,
      OP_ADDC = 4'd2,
      OP_SUB  = 4'd3,
      OP_SUBB = 4'd4,
      OP_ANDC = 4'd5,
      OP_ORC  = 4'd6,
      OP_CPLC = 4'd7,
      OP_SETC = 4'd8,
      OP_CLRC = 4'd9
   } alu_op_e;

   localparam int STATUS_W  = 8;
   localparam int BANK_BITS = 2;

   // stored part of the status byte, bits 7..1 in order
   typedef struct packed {
      logic                 cy;
      logic                 ac;
      logic                 fa;
      logic [BANK_BITS-1:0] bank;
      logic                 ov;
      logic                 fb;
   } psw_store_t;
endpackage

// File: rtl/psw_addsub.sv
module psw_addsub #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   input  logic         cflag,
   output logic [W-1:0] res,
   output logic         cy,
   output logic         ac,
   output logic         ov
);
   localparam int H = W / 2;

   logic [W-1:0] bx;
   logic         c0;
   logic [H:0]   lo;
   logic [W-1:0] mid;
   logic [W:0]   full;

   always_comb begin
      bx   = sub ? ~b : b;
      c0   = sub ? ~cflag : cflag;
      lo   = {1'b0, a[H-1:0]} + {1'b0, bx[H-1:0]} + {{H{1'b0}}, c0};
      mid  = {1'b0, a[W-2:0]} + {1'b0, bx[W-2:0]} + {{(W-1){1'b0}}, c0};
      full = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, c0};
      res  = full[W-1:0];
      cy   = sub ? ~full[W] : full[W];
      ac   = sub ? ~lo[H] : lo[H];
      ov   = mid[W-1] ^ full[W];
   end
endmodule

// File: rtl/psw_parity.sv
module psw_parity #(
   parameter int W = 8
) (
   input  logic [W-1:0] d,
   output logic         odd
);
   logic [W:0] chain;
   assign chain[0] = 1'b0;
   for (genvar i = 0; i < W; i++) begin : g_x
      assign chain[i+1] = chain[i] ^ d[i];
   end
   assign odd = chain[W];
endmodule

// File: rtl/psw_bank_map.sv
module psw_bank_map #(
   parameter int BANK_W = 2,
   parameter int SEL_W  = 3,
   parameter int ADDR_W = 8
) (
   input  logic [BANK_W-1:0] bank,
   input  logic [SEL_W-1:0]  reg_sel,
   input  logic              ptr_sel,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [ADDR_W-1:0] ptr_addr
);
   localparam int USED = BANK_W + SEL_W;

   if (ADDR_W < USED) begin : g_bad
      $error("psw_bank_map: ADDR_W too narrow for bank and register fields");
   end

   logic [USED-1:0] r_loc, p_loc;
   assign r_loc = {bank, reg_sel};
   assign p_loc = {bank, {(SEL_W-1){1'b0}}, ptr_sel};

   if (ADDR_W > USED) begin : g_pad
      assign reg_addr = {{(ADDR_W-USED){1'b0}}, r_loc};
      assign ptr_addr = {{(ADDR_W-USED){1'b0}}, p_loc};
   end else begin : g_exact
      assign reg_addr = r_loc;
      assign ptr_addr = p_loc;
   end
endmodule

// File: rtl/psw_unit.sv
module psw_unit
   import psw_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int SEL_W  = 3,
   parameter int ADDR_W = 8
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [DATA_W-1:0]   acc_i,
   input  logic [DATA_W-1:0]   opnd_i,
   input  logic [3:0]          alu_op_i,
   input  logic                bit_i,
   input  logic                sw_wr_i,
   input  logic [STATUS_W-1:0] sw_wdata_i,
   input  logic [SEL_W-1:0]    reg_sel_i,
   input  logic                ptr_sel_i,
   input  logic [DATA_W-1:0]   ptr_rdata_i,
   output logic [STATUS_W-1:0] psw_o,
   output logic [DATA_W-1:0]   sum_o,
   output logic [ADDR_W-1:0]   reg_addr_o,
   output logic [ADDR_W-1:0]   ptr_addr_o,
   output logic [DATA_W-1:0]   ind_addr_o
);
   if (DATA_W < 4 || (DATA_W % 2) != 0) begin : g_bad_w
      $error("psw_unit: DATA_W must be even and at least 4");
   end
   if (SEL_W < 1) begin : g_bad_sel
      $error("psw_unit: SEL_W must be at least 1");
   end

   psw_store_t st;
   alu_op_e    op;
   logic       is_sub, use_c, cin;
   logic       a_cy, a_ac, a_ov, par;

   assign op     = alu_op_e'(alu_op_i);
   assign is_sub = (op == OP_SUB) || (op == OP_SUBB);
   assign use_c  = (op == OP_ADDC) || (op == OP_SUBB);
   assign cin    = use_c & st.cy;

   psw_addsub #(.W(DATA_W)) u_addsub (
      .a(acc_i), .b(opnd_i), .sub(is_sub), .cflag(cin),
      .res(sum_o), .cy(a_cy), .ac(a_ac), .ov(a_ov)
   );

   psw_parity #(.W(DATA_W)) u_par (.d(acc_i), .odd(par));

   psw_bank_map #(.BANK_W(BANK_BITS), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_map (
      .bank(st.bank), .reg_sel(reg_sel_i), .ptr_sel(ptr_sel_i),
      .reg_addr(reg_addr_o), .ptr_addr(ptr_addr_o)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         st <= '0;
      end else if (sw_wr_i) begin
         st <= psw_store_t'(sw_wdata_i[STATUS_W-1:1]);
      end else begin
         case (op)
            OP_ADD, OP_ADDC, OP_SUB, OP_SUBB: begin
               st.cy <= a_cy;
               st.ac <= a_ac;
               st.ov <= a_ov;
            end
            OP_ANDC: st.cy <= st.cy & bit_i;
            OP_ORC:  st.cy <= st.cy | bit_i;
            OP_CPLC: st.cy <= ~st.cy;
            OP_SETC: st.cy <= 1'b1;
            OP_CLRC: st.cy <= 1'b0;
            default: ;
         endcase
      end
   end

   assign psw_o      = {st, par};
   assign ind_addr_o = ptr_rdata_i;
endmodule

// File: rtl/psw_unit_chk.sv
module psw_unit_chk #(
   parameter int DATA_W = 8,
   parameter int SEL_W  = 3,
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic [DATA_W-1:0] acc_i,
   input logic [3:0]        alu_op_i,
   input logic              sw_wr_i,
   input logic [7:0]        sw_wdata_i,
   input logic [SEL_W-1:0]  reg_sel_i,
   input logic [7:0]        psw_o,
   input logic [ADDR_W-1:0] reg_addr_o
);
   p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> psw_o[7:1] == 7'd0);

   p_parity_r6: assert property (@(posedge clk) disable iff (rst)
      psw_o[0] == (^acc_i));

   p_write_wins_r7: assert property (@(posedge clk) disable iff (rst)
      sw_wr_i |=> psw_o[7:1] == $past(sw_wdata_i[7:1]));

   p_bool_keeps_r8: assert property (@(posedge clk) disable iff (rst)
      (!sw_wr_i && alu_op_i >= 4'd5 && alu_op_i <= 4'd9) |=> $stable(psw_o[6:1]));

   p_setc_r8: assert property (@(posedge clk) disable iff (rst)
      (!sw_wr_i && alu_op_i == 4'd8) |=> psw_o[7]);

   p_clrc_r8: assert property (@(posedge clk) disable iff (rst)
      (!sw_wr_i && alu_op_i == 4'd9) |=> !psw_o[7]);

   p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
      (!sw_wr_i && (alu_op_i == 4'd0 || alu_op_i > 4'd9)) |=> $stable(psw_o[7:1]));

   p_bank_addr_r10: assert property (@(posedge clk) disable iff (rst)
      reg_addr_o[SEL_W +: 2] == psw_o[4:3] && reg_addr_o[SEL_W-1:0] == reg_sel_i);
endmodule

bind psw_unit psw_unit_chk #(.DATA_W(DATA_W), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst(rst), .acc_i(acc_i), .alu_op_i(alu_op_i), .sw_wr_i(sw_wr_i),
   .sw_wdata_i(sw_wdata_i), .reg_sel_i(reg_sel_i), .psw_o(psw_o), .reg_addr_o(reg_addr_o)
);

// File: tb/psw_unit_bench.sv
module psw_unit_bench;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] acc = 8'h00, opnd = 8'h00, wdata = 8'h00, prd = 8'h00;
   logic [3:0] op = 4'd0;
   logic       bitv = 1'b0, wr = 1'b0, psel = 1'b0;
   logic [2:0] rsel = 3'd0;
   logic [7:0] psw, sum, raddr, paddr, iaddr;

   int n_chk = 0, n_err = 0;
   logic [7:1] m = 7'd0;   // expected stored bits

   always #4 clk = ~clk;

   psw_unit u_psw_unit (
      .clk(clk), .rst(rst), .acc_i(acc), .opnd_i(opnd), .alu_op_i(op), .bit_i(bitv),
      .sw_wr_i(wr), .sw_wdata_i(wdata), .reg_sel_i(rsel), .ptr_sel_i(psel),
      .ptr_rdata_i(prd), .psw_o(psw), .sum_o(sum), .reg_addr_o(raddr),
      .ptr_addr_o(paddr), .ind_addr_o(iaddr)
   );

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic parity(logic [7:0] v);
      return ($countones(v) % 2) == 1;
   endfunction

   function automatic int sgn(int v);
      return (v >= 128) ? v - 256 : v;
   endfunction

   // one ALU op: check sum before the edge, status after it
   task automatic do_op(string req, int code, int a, int b, logic bv);
      int r, sv, cin;
      logic [7:0] esum;
      @(negedge clk);
      acc = a[7:0]; opnd = b[7:0]; op = code[3:0]; bitv = bv;
      cin = (code == 2 || code == 4) ? int'(m[7]) : 0;
      esum = 8'h00;
      if (code == 1 || code == 2) begin
         r = a + b + cin; esum = r[7:0];
         sv = sgn(a) + sgn(b) + cin;
         m[7] = r > 255;
         m[6] = ((a % 16) + (b % 16) + cin) > 15;
         m[2] = (sv > 127) || (sv < -128);
      end else if (code == 3 || code == 4) begin
         r = a - b - cin; esum = r[7:0];
         sv = sgn(a) - sgn(b) - cin;
         m[7] = r < 0;
         m[6] = ((a % 16) - (b % 16) - cin) < 0;
         m[2] = (sv > 127) || (sv < -128);
      end else if (code == 5) m[7] = m[7] & bv;
      else if (code == 6) m[7] = m[7] | bv;
      else if (code == 7) m[7] = ~m[7];
      else if (code == 8) m[7] = 1'b1;
      else if (code == 9) m[7] = 1'b0;
      #1;
      if (code >= 1 && code <= 4) chk({req, " sum"}, sum, esum);
      @(posedge clk);
      @(negedge clk);
      chk({req, " status"}, psw, {m, parity(acc)});
      op = 4'd0;
   endtask

   task automatic do_write(string req, logic [7:0] d, int code);
      @(negedge clk);
      wr = 1'b1; wdata = d; op = code[3:0]; acc = 8'h5A; opnd = 8'hC3;
      m = d[7:1];
      @(posedge clk);
      @(negedge clk);
      wr = 1'b0; op = 4'd0;
      chk(req, psw, {m, parity(acc)});
   endtask

   task automatic t_reset_r1();
      acc = 8'h07;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      chk("R1 reset value", psw, {7'd0, 1'b1});
   endtask

   task automatic t_layout_r2();
      do_write("R2 software flags at bits 5 and 1", 8'b0010_0010, 0);
      chk("R2 flag A bit5", {7'd0, psw[5]}, 8'd1);
      chk("R2 flag B bit1", {7'd0, psw[1]}, 8'd1);
      do_write("R2 clear", 8'h00, 0);
   endtask

   task automatic t_add_r3();
      do_op("R3 add plain", 1, 8'h12, 8'h34, 1'b0);
      do_op("R3 add half carry", 1, 8'h0F, 8'h01, 1'b0);
      do_op("R3 add carry out", 1, 8'hF0, 8'h20, 1'b0);
      do_op("R3 addc with carry set", 2, 8'h0E, 8'h01, 1'b0);
      do_op("R3 addc carry clear", 2, 8'h01, 8'h01, 1'b0);
   endtask

   task automatic t_sub_r4();
      do_op("R4 sub borrow", 3, 8'h10, 8'h20, 1'b0);
      do_op("R4 subb with borrow in", 4, 8'h10, 8'h05, 1'b0);
      do_op("R4 sub no borrow", 3, 8'h55, 8'h11, 1'b0);
      do_write("R4 preload carry", 8'h80, 0);
      do_op("R4 subb borrow to zero", 4, 8'h01, 8'h00, 1'b0);
   endtask

   task automatic t_ov_r5();
      do_op("R5 pos+pos overflow", 1, 8'h7F, 8'h01, 1'b0);
      do_op("R5 neg+neg overflow", 1, 8'h80, 8'h80, 1'b0);
      do_op("R5 neg-pos overflow", 3, 8'h80, 8'h01, 1'b0);
      do_op("R5 no overflow mixed", 1, 8'hFF, 8'h01, 1'b0);
   endtask

   task automatic t_parity_r6();
      @(negedge clk);
      acc = 8'h01; #1 chk("R6 parity odd", {7'd0, psw[0]}, 8'd1);
      acc = 8'h03; #1 chk("R6 parity even", {7'd0, psw[0]}, 8'd0);
      acc = 8'hFE; #1 chk("R6 parity seven", {7'd0, psw[0]}, 8'd1);
      do_write("R6 bit0 write ignored", 8'h01, 0);
   endtask

   task automatic t_write_r7();
      do_write("R7 write all", 8'hFE, 0);
      do_write("R7 write beats add", 8'h40, 1);
      do_write("R7 write beats setc", 8'h00, 8);
   endtask

   task automatic t_bool_r8();
      do_write("R8 preload", 8'b0110_0110, 0);
      do_op("R8 setc", 8, 0, 0, 1'b0);
      do_op("R8 and with 0", 5, 0, 0, 1'b0);
      do_op("R8 or with 1", 6, 0, 0, 1'b1);
      do_op("R8 and with 1", 5, 0, 0, 1'b1);
      do_op("R8 complement", 7, 0, 0, 1'b0);
      do_op("R8 or with 0", 6, 0, 0, 1'b0);
      do_op("R8 complement back", 7, 0, 0, 1'b0);
      do_op("R8 clear", 9, 0, 0, 1'b0);
   endtask

   task automatic t_idle_r9();
      do_write("R9 preload", 8'hAA, 0);
      do_op("R9 nop", 0, 8'hFF, 8'hFF, 1'b1);
      do_op("R9 code 12", 12, 8'h7F, 8'h7F, 1'b0);
      do_op("R9 code 15", 15, 8'h80, 8'h80, 1'b1);
   endtask

   task automatic t_bank_r10();
      for (int bk = 0; bk < 4; bk++) begin
         do_write("R10 bank select", {3'b000, bk[1:0], 3'b000}, 0);
         for (int n = 0; n < 8; n += 7) begin
            rsel = n[2:0]; #1;
            chk("R10 register address", raddr, 8'(bk * 8 + n));
         end
      end
   endtask

   task automatic t_ind_r11();
      do_write("R11 bank 2", 8'h10, 0);
      psel = 1'b0; prd = 8'h3C; #1;
      chk("R11 pointer R0 address", paddr, 8'h10);
      chk("R11 indirect address", iaddr, 8'h3C);
      psel = 1'b1; prd = 8'hE1; #1;
      chk("R11 pointer R1 address", paddr, 8'h11);
      chk("R11 indirect address 2", iaddr, 8'hE1);
      do_write("R11 bank 3", 8'h18, 0);
      #1 chk("R11 pointer after bank change", paddr, 8'h19);
   endtask

   task automatic t_rereset_r1();
      do_write("R1 preload", 8'hFE, 0);
      @(negedge clk);
      rst = 1'b1; acc = 8'h00;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0; m = 7'd0;
      chk("R1 mid-run reset", psw, 8'h00);
      chk("R1 bank 0 after reset", raddr, {5'd0, rsel});
   endtask

   initial begin
      #(8 * 100000);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      t_reset_r1();
      t_layout_r2();
      t_add_r3();
      t_sub_r4();
      t_ov_r5();
      t_parity_r6();
      t_write_r7();
      t_bool_r8();
      t_idle_r9();
      t_bank_r10();
      t_ind_r11();
      t_rereset_r1();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule